// File: doc/BRIEF.md
# Byte Register Space with Consistent Time Capture

This block is the register file that sits behind a serial-bus slave. The bus front end hands it one strobe per event: a bus start, a byte arriving from the master, or a byte the master wants to fetch. The block answers from a 256-location byte space. The lowest locations mirror a running clock. Above them sit control bytes, and the rest is general-purpose storage. A single pointer chooses the location for every access. The first byte written after a bus start loads the pointer. Every data byte written or read afterwards advances it, and it rolls over from the top of the space to location zero.

Software reads time over several bytes while the clock keeps counting, so the time locations are never read live. The block keeps a shadow copy of the clock bytes. It refreshes that copy from the live time bus on each bus start and each time the pointer steps onto location zero. Reads of the time locations return the shadow. A write to a time location is passed out on a write port, so the counters outside the block can be loaded, and the same write updates the shadow. An access-enable input reflects whether a valid supply is present. While it is low the block ignores every strobe.

Top module: `tsnap_regmap`

## Requirements
- R1: After reset, `rd_data` is 00h, the pointer is 00h, the shadow bytes are 00h, the control bytes (from `NT` up to `GP_LO`-1, default 07h–13h) read 00h, and the next written byte is treated as an address.
- R2: The first byte written after a bus start (or after reset) loads the pointer and is not stored anywhere.
- R3: Each later written byte is stored at the pointer location, and the pointer then increments; a read of that location returns the stored byte.
- R4: A read strobe puts the byte at the pointer on `rd_data` from the next clock edge and increments the pointer; without an accepted read, `rd_data` holds its value.
- R5: The pointer increments from FFh to 00h.
- R6: On an accepted bus start the live time bus is copied into the shadow; reads of locations 00h to `NT`-1 return the shadow, not later live values.
- R7: When a data write or a read moves the pointer onto 00h, the live time is copied into the shadow at that same edge.
- R8: Loading the pointer with 00h through an address byte does not refresh the shadow.
- R9: A data write to a location below `NT` raises `time_wr_en` in the same cycle, with `time_wr_addr` equal to the pointer and `time_wr_data` equal to the byte, and updates that shadow byte.
- R10: While `acc_en` is low, bus starts and strobes have no effect: no pointer change, no store, no shadow refresh, and `rd_data` holds.
- R11: Priority within one cycle: a bus start beats both strobes (they are dropped), and a write strobe beats a read strobe (the read is dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access enable: high while a valid supply is present |
| bus_start | input | 1 | One-cycle pulse: bus start seen |
| wr_stb | input | 1 | One-cycle pulse: byte received from the master |
| rd_stb | input | 1 | One-cycle pulse: byte requested by the master |
| wr_data | input | 8 | Received byte |
| rd_data | output | 8 | Byte returned for the last accepted read |
| live_time | input | NT*8 | Running clock counters, byte i at bits i*8+7:i*8 |
| time_wr_en | output | 1 | Write to a live time counter this cycle |
| time_wr_addr | output | $clog2(NT) | Index of the time byte written |
| time_wr_data | output | 8 | Value for the time byte |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer (256 locations), seven time bytes and general storage from 14h. With these values the FFh-to-00h rollover is one address load away, so both ways of reaching 00h can be driven directly: a data write and a read. The control bytes between the time bytes and the general storage have a defined reset value that can be read back. Random traffic loads addresses across the whole space and mixes in disabled cycles and colliding strobes. Each read is compared with a model that tracks the pointer, the shadow and every written byte.

// File: rtl/tsnap_pkg.sv
`timescale 1ns/1ps
package tsnap_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    // Kind of access accepted in the current cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_ADDR  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_READ  = 2'd3
    } acc_e;
endpackage

// File: rtl/tsnap_ptr.sv
`timescale 1ns/1ps
// Pointer and address-phase control; flags a shadow refresh.
module tsnap_ptr
    import tsnap_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          bus_start,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  byte_t         wr_data,
    output logic [AW-1:0] ptr,
    output acc_e          kind,
    output logic          snap
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          addr_phase;
    } st_t;

    st_t  st_d, st_q;
    logic step;

    always_comb begin
        st_d = st_q;
        kind = ACC_IDLE;
        step = 1'b0;
        snap = 1'b0;
        if (acc_en) begin
            if (bus_start) begin
                st_d.addr_phase = 1'b1;
                snap            = 1'b1;
            end else if (wr_stb) begin
                if (st_q.addr_phase) begin
                    kind            = ACC_ADDR;
                    st_d.ptr        = wr_data[AW-1:0];
                    st_d.addr_phase = 1'b0;
                end else begin
                    kind = ACC_WRITE;
                    step = 1'b1;
                end
            end else if (rd_stb) begin
                kind = ACC_READ;
                step = 1'b1;
            end
        end
        if (step) begin
            st_d.ptr = st_q.ptr + 1'b1;
            snap     = (st_d.ptr == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr        <= '0;
            st_q.addr_phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/tsnap_shadow.sv
`timescale 1ns/1ps
// Secondary copy of the time bytes.
module tsnap_shadow
    import tsnap_pkg::*;
#(
    parameter int NT  = 7,
    parameter int TAW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NT*8-1:0] live,
    input  logic            snap,
    input  logic            wr_en,
    input  logic [TAW-1:0]  wr_idx,
    input  byte_t           wr_val,
    output logic [NT*8-1:0] shadow
);
    byte_t sh_d [NT];
    byte_t sh_q [NT];

    for (genvar i = 0; i < NT; i++) begin : g_byte
        always_comb begin
            sh_d[i] = sh_q[i];
            if (snap) sh_d[i] = live[i*8 +: 8];
            if (wr_en && wr_idx == TAW'(i)) sh_d[i] = wr_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= '0;
            else        sh_q[i] <= sh_d[i];
        end

        assign shadow[i*8 +: 8] = sh_q[i];
    end
endmodule

// File: rtl/tsnap_store.sv
`timescale 1ns/1ps
// Control bytes (reset to zero) and general storage (no reset).
module tsnap_store
    import tsnap_pkg::*;
#(
    parameter int AW     = 8,
    parameter int CTL_LO = 7,
    parameter int GP_LO  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  byte_t         wdata,
    output byte_t         rdata
);
    localparam int DEPTH = 1 << AW;

    byte_t rd_arr [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_loc
        if (a < CTL_LO) begin : g_unused
            assign rd_arr[a] = '0;
        end else if (a < GP_LO) begin : g_ctl
            byte_t loc_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                     loc_q <= '0;
                else if (we && addr == AW'(a))  loc_q <= wdata;
            end
            assign rd_arr[a] = loc_q;
        end else begin : g_gp
            byte_t loc_q;
            always_ff @(posedge clk) begin
                if (we && addr == AW'(a)) loc_q <= wdata;
            end
            assign rd_arr[a] = loc_q;
        end
    end

    assign rdata = rd_arr[addr];
endmodule

// File: rtl/tsnap_regmap.sv
`timescale 1ns/1ps
// Register space with time snapshot behind a serial-bus slave.
module tsnap_regmap
    import tsnap_pkg::*;
#(
    parameter int AW    = 8,
    parameter int NT    = 7,
    parameter int GP_LO = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_en,
    input  logic                  bus_start,
    input  logic                  wr_stb,
    input  logic                  rd_stb,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    input  logic [NT*8-1:0]       live_time,
    output logic                  time_wr_en,
    output logic [$clog2(NT)-1:0] time_wr_addr,
    output logic [7:0]            time_wr_data
);
    localparam int TAW = $clog2(NT);

    logic [AW-1:0]   ptr;
    acc_e            kind;
    logic            snap;
    logic            is_time;
    logic [NT*8-1:0] shadow_flat;
    byte_t           store_rdata;
    byte_t           sh_byte;
    byte_t           rd_d, rd_q;

    tsnap_ptr #(.AW(AW)) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .bus_start (bus_start),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .kind      (kind),
        .snap      (snap)
    );

    assign is_time      = (ptr < AW'(NT));
    assign time_wr_en   = (kind == ACC_WRITE) && is_time;
    assign time_wr_addr = ptr[TAW-1:0];
    assign time_wr_data = wr_data;

    tsnap_shadow #(.NT(NT), .TAW(TAW)) shadow_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (live_time),
        .snap   (snap),
        .wr_en  (time_wr_en),
        .wr_idx (ptr[TAW-1:0]),
        .wr_val (wr_data),
        .shadow (shadow_flat)
    );

    tsnap_store #(.AW(AW), .CTL_LO(NT), .GP_LO(GP_LO)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ((kind == ACC_WRITE) && !is_time),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (store_rdata)
    );

    always_comb begin
        sh_byte = '0;
        for (int i = 0; i < NT; i++) begin
            if (ptr == AW'(i)) sh_byte = shadow_flat[i*8 +: 8];
        end
        rd_d = rd_q;
        if (kind == ACC_READ) rd_d = is_time ? sh_byte : store_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/tsnap_regmap_chk.sv
`timescale 1ns/1ps
module tsnap_regmap_chk #(
    parameter int AW = 8,
    parameter int NT = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_en,
    input logic                  bus_start,
    input logic                  wr_stb,
    input logic                  rd_stb,
    input logic [7:0]            rd_data,
    input logic [NT*8-1:0]       live_time,
    input logic                  time_wr_en,
    input logic [$clog2(NT)-1:0] time_wr_addr,
    input logic [AW-1:0]         ptr,
    input logic [NT*8-1:0]       shadow_flat
);
    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && rd_stb && !wr_stb && !bus_start) |=> $stable(rd_data));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> ($stable(ptr) && $stable(shadow_flat)));

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !bus_start && !wr_stb && rd_stb && ptr == '1) |=> (ptr == '0));

    // R7
    wrap_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !bus_start && !wr_stb && rd_stb && ptr == '1)
            |=> (shadow_flat == $past(live_time)));

    // R6
    start_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && bus_start) |=> (shadow_flat == $past(live_time)));

    // R9
    time_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr_en |-> (acc_en && wr_stb && !bus_start && int'(time_wr_addr) < NT));
endmodule

bind tsnap_regmap tsnap_regmap_chk #(.AW(AW), .NT(NT)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en       (acc_en),
    .bus_start    (bus_start),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .rd_data      (rd_data),
    .live_time    (live_time),
    .time_wr_en   (time_wr_en),
    .time_wr_addr (time_wr_addr),
    .ptr          (ptr),
    .shadow_flat  (shadow_flat)
);

// File: tb/tsnap_regmap_tb_top.sv
`timescale 1ns/1ps
module tsnap_regmap_tb_top;
    localparam int AW    = 8;
    localparam int NT    = 7;
    localparam int GP_LO = 20;
    localparam int DEPTH = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_en = 1'b0;
    logic            bus_start = 1'b0;
    logic            wr_stb = 1'b0;
    logic            rd_stb = 1'b0;
    logic [7:0]      wr_data = '0;
    logic [7:0]      rd_data;
    logic [NT*8-1:0] live_time = '0;
    logic            time_wr_en;
    logic [2:0]      time_wr_addr;
    logic [7:0]      time_wr_data;

    always #2.5 clk = ~clk;

    tsnap_regmap #(.AW(AW), .NT(NT), .GP_LO(GP_LO)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_en       (acc_en),
        .bus_start    (bus_start),
        .wr_stb       (wr_stb),
        .rd_stb       (rd_stb),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .live_time    (live_time),
        .time_wr_en   (time_wr_en),
        .time_wr_addr (time_wr_addr),
        .time_wr_data (time_wr_data)
    );

    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;

    logic [7:0] mem_m  [DEPTH];
    bit         known_m[DEPTH];
    logic [7:0] sh_m   [NT];
    logic [7:0] live_m [NT];
    int         ptr_m;
    bit         phase_m;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int a);
        return (a < NT) ? sh_m[a] : mem_m[a];
    endfunction

    task automatic set_live();
        for (int i = 0; i < NT; i++) begin
            live_m[i] = 8'($urandom);
            live_time[i*8 +: 8] = live_m[i];
        end
    endtask

    task automatic step_ptr();
        ptr_m = (ptr_m + 1) % DEPTH;
        if (ptr_m == 0) sh_m = live_m;   // R7 refresh on increment to 00h
    endtask

    // One cycle of stimulus, called at a falling edge; returns at the next one.
    task automatic op(bit a, bit s, bit w, bit r, logic [7:0] d, string tag);
        logic [7:0] prev;
        logic [7:0] exp_rd;
        bit         rd_eff;
        bit         rd_chk;
        bit         tw_exp;
        prev      = rd_data;
        acc_en    = a;
        bus_start = s;
        wr_stb    = w;
        rd_stb    = r;
        wr_data   = d;
        tw_exp    = a && !s && w && !phase_m && (ptr_m < NT);
        #1;
        chk({tag, " R9 time_wr_en"}, 32'(time_wr_en), 32'(tw_exp));
        if (tw_exp) begin
            chk({tag, " R9 time_wr_addr"}, 32'(time_wr_addr), 32'(ptr_m));
            chk({tag, " R9 time_wr_data"}, 32'(time_wr_data), 32'(d));
        end
        rd_eff = 1'b0;
        rd_chk = 1'b0;
        exp_rd = '0;
        if (a) begin
            if (s) begin
                phase_m = 1'b1;
                sh_m    = live_m;
            end else if (w) begin
                if (phase_m) begin
                    ptr_m   = int'(d);
                    phase_m = 1'b0;
                end else begin
                    if (ptr_m < NT) sh_m[ptr_m] = d;
                    else begin
                        mem_m[ptr_m]   = d;
                        known_m[ptr_m] = 1'b1;
                    end
                    step_ptr();
                end
            end else if (r) begin
                rd_eff = 1'b1;
                rd_chk = (ptr_m < NT) || known_m[ptr_m];
                exp_rd = exp_byte(ptr_m);
                step_ptr();
            end
        end
        @(negedge clk);
        acc_en    = 1'b1;
        bus_start = 1'b0;
        wr_stb    = 1'b0;
        rd_stb    = 1'b0;
        if (rd_eff) begin
            if (rd_chk) chk({tag, " rd_data"}, 32'(rd_data), 32'(exp_rd));
        end else begin
            chk({tag, " R4 R10 rd_data held"}, 32'(rd_data), 32'(prev));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) begin
            mem_m[i]   = '0;
            known_m[i] = (i >= NT) && (i < GP_LO);
        end
        for (int i = 0; i < NT; i++) begin
            sh_m[i]   = '0;
            live_m[i] = '0;
        end
        ptr_m   = 0;
        phase_m = 1'b1;

        repeat (4) @(negedge clk);
        rst_n  = 1'b1;
        acc_en = 1'b1;
        // R1 reset state
        chk("R1 rd_data after reset", 32'(rd_data), 32'h0);
        chk("R1 time_wr_en after reset", 32'(time_wr_en), 32'h0);
        set_live();
        op(1, 0, 0, 1, 8'h00, "R1 shadow reset read at 00h");
        op(1, 0, 1, 0, 8'h07, "R1 R2 first byte loads pointer");
        for (int i = NT; i < GP_LO; i++) op(1, 0, 0, 1, 8'h00, "R1 control byte reset");

        // R2 R3 address byte is not stored, data bytes are
        op(1, 1, 0, 0, 8'h00, "R6 start");
        op(1, 0, 1, 0, 8'h40, "R2 address 40h");
        op(1, 0, 1, 0, 8'h11, "R3 store 40h");
        op(1, 0, 1, 0, 8'h22, "R3 store 41h");
        op(1, 1, 0, 0, 8'h00, "R6 start");
        op(1, 0, 1, 0, 8'h40, "R2 address 40h again");
        op(1, 0, 0, 1, 8'h00, "R2 R3 read 40h");
        op(1, 0, 0, 1, 8'h00, "R3 R4 read 41h");

        // R9 time write through the write port, shadow updated
        op(1, 1, 0, 0, 8'h00, "R6 start");
        op(1, 0, 1, 0, 8'h02, "R2 address 02h");
        op(1, 0, 1, 0, 8'h5a, "R9 write time 02h");
        op(1, 0, 1, 0, 8'ha5, "R9 write time 03h");
        op(1, 1, 0, 0, 8'h00, "R6 start");
        set_live();
        op(1, 0, 1, 0, 8'h00, "R2 address 00h");
        for (int i = 0; i < NT; i++) op(1, 0, 0, 1, 8'h00, "R6 shadow read not live");

        // R5 R7 wrap by data write
        op(1, 1, 0, 0, 8'h00, "R6 start");
        op(1, 0, 1, 0, 8'hfe, "R2 address FEh");
        op(1, 0, 1, 0, 8'h33, "R3 store FEh");
        set_live();
        op(1, 0, 1, 0, 8'h44, "R5 R7 store FFh wraps");
        set_live();
        op(1, 0, 0, 1, 8'h00, "R5 R7 read 00h after write wrap");
        op(1, 0, 0, 1, 8'h00, "R7 read 01h after write wrap");

        // R5 R7 wrap by read
        op(1, 1, 0, 0, 8'h00, "R6 start");
        op(1, 0, 1, 0, 8'hff, "R2 address FFh");
        set_live();
        op(1, 0, 0, 1, 8'h00, "R5 read FFh");
        set_live();
        op(1, 0, 0, 1, 8'h00, "R5 R7 read 00h after read wrap");

        // R8 loading 00h does not refresh
        set_live();
        op(1, 1, 0, 0, 8'h00, "R6 start");
        set_live();
        op(1, 0, 1, 0, 8'h00, "R8 address 00h");
        op(1, 0, 0, 1, 8'h00, "R8 read 00h keeps start copy");

        // R10 disabled strobes
        op(0, 1, 0, 0, 8'h00, "R10 start ignored");
        op(0, 0, 1, 0, 8'h77, "R10 write ignored");
        op(0, 0, 0, 1, 8'h00, "R10 read ignored");
        op(1, 0, 0, 1, 8'h00, "R10 pointer unchanged read 01h");

        // R11 priorities
        op(1, 1, 0, 0, 8'h00, "R6 start");
        op(1, 0, 1, 0, 8'h50, "R2 address 50h");
        op(1, 0, 1, 1, 8'h66, "R11 write beats read");
        op(1, 1, 1, 1, 8'h99, "R11 start beats strobes");
        op(1, 0, 1, 0, 8'h50, "R11 R2 address after start");
        op(1, 0, 0, 1, 8'h00, "R11 read 50h");
        op(1, 0, 0, 1, 8'h00, "R11 read 51h untouched");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            int  k;
            bit  a, s, w, r;
            k = int'($urandom % 16);
            if (k == 15) set_live();
            a = ($urandom % 10) != 0;
            s = (k < 2);
            w = ($urandom % 2) == 1;
            r = ($urandom % 2) == 1;
            if (k == 3) begin
                w = 1'b1;
                r = 1'b0;
            end
            op(a, s, w, r, 8'($urandom), "random R3 R4 R6");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule